// File: doc/BRIEF.md
# Asynchronous DRAM Controller with Distributed Refresh

This block connects a simple synchronous request port to an asynchronous DRAM device. The request port uses a valid/ready handshake. Each request carries a read/write flag, a flat address and write data. Read results come back on a separate one-cycle response pulse.

For every accepted request the controller splits the flat address. The upper half goes out as the row and the lower half as the column. The controller then steps the row strobe, column strobe and write-enable lines through fixed cycle counts set by parameters. The device's output enable is assumed tied active, so the device drives data whenever both strobes are low and write enable is high.

A free-running refresh timer raises a refresh request at a fixed cycle interval. An internal row counter supplies the row for each refresh. One row is refreshed per request, so the refreshes are spread evenly across the retention window and never come as one burst. A refresh that falls due while an access is in progress waits for that access to finish. It then runs before any new request is accepted.

Top module: `dram_ctl`

## Requirements
- R1: While reset is asserted and right after it, both strobes and write enable are high (inactive), data drive is off, the response valid is low, and the request port shows ready.
- R2: The row is the upper ADDR_W bits of the request address and the column is the lower ADDR_W bits. Each is on the DRAM address bus, unchanged, for at least one cycle before its strobe falls.
- R3: Within an access the row strobe is low for T_RCD+1 cycles before the column strobe falls. The column strobe stays low for exactly T_CAS cycles and is low only while the row strobe is low. The row strobe stays high for at least T_RP+1 cycles between two low periods.
- R4: For a write, write enable goes low before the column strobe falls and stays low while it is low, and data drive is on with the request's data. For a read, write enable stays high and data drive stays off.
- R5: A read returns the device data sampled in the last column-strobe-low cycle, with a response valid that is high for exactly one cycle.
- R6: A refresh pulses the row strobe low for T_RCD+T_CAS cycles with the column strobe held high. The address bus carries a row counter that starts at 0 after reset and steps by one, wrapping, after each refresh.
- R7: Refreshes are issued every REF_INTERVAL = (CLK_KHZ*RETENTION_MS - (4+T_RCD+T_CAS+T_RP)) / 2^ADDR_W cycles (integer division), give or take one access. Every row is therefore refreshed at least once within CLK_KHZ*RETENTION_MS cycles.
- R8: A refresh that is due takes priority over requests. Under back-to-back traffic, consecutive refreshes stay no more than REF_INTERVAL+T_RCD+T_CAS+T_RP+4 cycles apart.
- R9: A request is taken only when valid and ready are both high. Ready is low from the cycle after acceptance until the access and its precharge are over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*ADDR_W | Flat address, row in upper half |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | DATA_W | Read data |
| dram_addr | output | ADDR_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Data toward the device |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data from the device |

## Verification
The assertions assume the request fields stay steady while req_valid is high and ready is low. The bench's driver sets them at a falling edge and holds them until the handshake completes. The scheduler check assumes that one access plus one refresh always fits inside one refresh interval. The bench parameters (a 39-cycle interval against 8-cycle accesses) keep to that. The device model in the bench returns data only after the column strobe has fallen, which matches the sample point the read path relies on.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RSET, S_RCD, S_CSET, S_CAS, S_PRE, S_FSET, S_FRAS
  } seq_state_t;

  typedef enum logic [1:0] {
    SEL_ROW, SEL_COL, SEL_REF
  } addr_sel_t;
endpackage

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROW_W    = 12,
  parameter int INTERVAL = 1562
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_ack,
  input  logic             ref_done,
  output logic             ref_pending,
  output logic [ROW_W-1:0] ref_row
);
  localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0]    timer_q, timer_d;
  logic             pend_q, pend_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             tick;

  assign tick = (timer_q == LAST);

  always_comb begin
    timer_d = tick ? '0 : timer_q + TW'(1);
    pend_d  = pend_q;
    if (ref_ack) pend_d = 1'b0;
    if (tick)    pend_d = 1'b1;
    row_d   = row_q + ROW_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= '0;
      pend_q  <= 1'b0;
      row_q   <= '0;
    end else begin
      timer_q <= timer_d;
      pend_q  <= pend_d;
      if (ref_done) row_q <= row_d;
    end
  end

  assign ref_pending = pend_q;
  assign ref_row     = row_q;

  // R7
  no_lost_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !pend_q);

  // R6
  ack_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |-> pend_q);
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_ctl_pkg::*;
#(
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_RP  = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      ref_pending,
  input  logic      lat_wr,
  output logic      req_ready,
  output logic      accept,
  output logic      ref_ack,
  output logic      ref_done,
  output logic      cap_en,
  output addr_sel_t addr_sel,
  output logic      ras_n,
  output logic      cas_n,
  output logic      we_n,
  output logic      dq_oe
);
  localparam int REF_LOW = T_RCD + T_CAS;
  localparam int MAXD    = (REF_LOW > T_RP) ? REF_LOW : T_RP;
  localparam int CW      = $clog2(MAXD + 1);
  localparam logic [CW-1:0] LD_RCD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] LD_CAS = CW'(T_CAS - 1);
  localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] LD_REF = CW'(REF_LOW - 1);

  seq_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_zero;

  assign cnt_zero  = (cnt_q == '0);
  assign req_ready = (state_q == S_IDLE) && !ref_pending;
  assign accept    = req_ready && req_valid;
  assign ref_ack   = (state_q == S_FSET);
  assign ref_done  = (state_q == S_FRAS) && cnt_zero;
  assign cap_en    = (state_q == S_CAS) && cnt_zero && !lat_wr;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_zero ? '0 : cnt_q - CW'(1);
    case (state_q)
      S_IDLE: begin
        if (ref_pending) state_d = S_FSET;
        else if (req_valid) state_d = S_RSET;
      end
      S_RSET: begin
        state_d = S_RCD;
        cnt_d   = LD_RCD;
      end
      S_RCD:  if (cnt_zero) state_d = S_CSET;
      S_CSET: begin
        state_d = S_CAS;
        cnt_d   = LD_CAS;
      end
      S_CAS: if (cnt_zero) begin
        state_d = S_PRE;
        cnt_d   = LD_RP;
      end
      S_PRE: if (cnt_zero) state_d = ref_pending ? S_FSET : S_IDLE;
      S_FSET: begin
        state_d = S_FRAS;
        cnt_d   = LD_REF;
      end
      S_FRAS: if (cnt_zero) begin
        state_d = S_PRE;
        cnt_d   = LD_RP;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    ras_n    = 1'b1;
    cas_n    = 1'b1;
    we_n     = 1'b1;
    dq_oe    = 1'b0;
    addr_sel = SEL_ROW;
    case (state_q)
      S_RCD:  ras_n = 1'b0;
      S_CSET: begin
        ras_n    = 1'b0;
        addr_sel = SEL_COL;
        we_n     = !lat_wr;
        dq_oe    = lat_wr;
      end
      S_CAS: begin
        ras_n    = 1'b0;
        cas_n    = 1'b0;
        addr_sel = SEL_COL;
        we_n     = !lat_wr;
        dq_oe    = lat_wr;
      end
      S_FSET: addr_sel = SEL_REF;
      S_FRAS: begin
        ras_n    = 1'b0;
        addr_sel = SEL_REF;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R3
  cas_needs_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  // R4
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n)) |-> $stable(we_n));

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
endmodule

// File: rtl/dram_datapath.sv
module dram_datapath
  import dram_ctl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [2*ADDR_W-1:0] req_addr,
  input  logic                req_wr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  addr_sel_t           addr_sel,
  input  logic [ADDR_W-1:0]   ref_row,
  input  logic                cap_en,
  input  logic [DATA_W-1:0]   dq_in,
  output logic                lat_wr,
  output logic [ADDR_W-1:0]   dram_addr,
  output logic [DATA_W-1:0]   dq_out,
  output logic [DATA_W-1:0]   rdata,
  output logic                rvalid
);
  logic [2*ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]   wdata_q, rdata_q;
  logic                wr_q, rvalid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      wr_q    <= req_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= cap_en;
      if (cap_en) rdata_q <= dq_in;
    end
  end

  always_comb begin
    case (addr_sel)
      SEL_COL: dram_addr = addr_q[ADDR_W-1:0];
      SEL_REF: dram_addr = ref_row;
      default: dram_addr = addr_q[2*ADDR_W-1:ADDR_W];
    endcase
  end

  assign lat_wr = wr_q;
  assign dq_out = wdata_q;
  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  // R5
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_q |=> !rvalid_q);
endmodule

// File: rtl/dram_ctl.sv
module dram_ctl
  import dram_ctl_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 16,
  parameter int CLK_KHZ      = 100000,
  parameter int RETENTION_MS = 64,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_wr,
  input  logic [2*ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]   dram_addr,
  output logic                dram_ras_n,
  output logic                dram_cas_n,
  output logic                dram_we_n,
  output logic [DATA_W-1:0]   dram_dq_out,
  output logic                dram_dq_oe,
  input  logic [DATA_W-1:0]   dram_dq_in
);
  localparam int ROWS         = 1 << ADDR_W;
  localparam int WINDOW_CYC   = CLK_KHZ * RETENTION_MS;
  localparam int SLACK        = 4 + T_RCD + T_CAS + T_RP;
  localparam int REF_INTERVAL = (WINDOW_CYC - SLACK) / ROWS;

  logic [1:0]        rst_sync;
  logic              rst_sync_n;
  logic              accept, ref_ack, ref_done, cap_en, ref_pending, lat_wr;
  logic [ADDR_W-1:0] ref_row;
  addr_sel_t         addr_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  dram_refresh_sched #(
    .ROW_W    (ADDR_W),
    .INTERVAL (REF_INTERVAL)
  ) u_sched (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ref_ack     (ref_ack),
    .ref_done    (ref_done),
    .ref_pending (ref_pending),
    .ref_row     (ref_row)
  );

  dram_seq_fsm #(
    .T_RCD (T_RCD),
    .T_CAS (T_CAS),
    .T_RP  (T_RP)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_valid   (req_valid),
    .ref_pending (ref_pending),
    .lat_wr      (lat_wr),
    .req_ready   (req_ready),
    .accept      (accept),
    .ref_ack     (ref_ack),
    .ref_done    (ref_done),
    .cap_en      (cap_en),
    .addr_sel    (addr_sel),
    .ras_n       (dram_ras_n),
    .cas_n       (dram_cas_n),
    .we_n        (dram_we_n),
    .dq_oe       (dram_dq_oe)
  );

  dram_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wr    (req_wr),
    .req_wdata (req_wdata),
    .addr_sel  (addr_sel),
    .ref_row   (ref_row),
    .cap_en    (cap_en),
    .dq_in     (dram_dq_in),
    .lat_wr    (lat_wr),
    .dram_addr (dram_addr),
    .dq_out    (dram_dq_out),
    .rdata     (rsp_rdata),
    .rvalid    (rsp_valid)
  );

  // R2
  row_setup_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(dram_ras_n) |-> $stable(dram_addr));

  // R2
  col_setup_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(dram_cas_n) |-> ($stable(dram_addr) && $stable(dram_we_n)));

  // R4
  drive_only_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dram_dq_oe |-> !dram_we_n);
endmodule

// File: tb/sim_dram_ctl.sv
module sim_dram_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int AW     = 4;
  localparam int DW     = 8;
  localparam int NROWS  = 16;
  localparam int TRCD   = 2;
  localparam int TCAS   = 2;
  localparam int TRP    = 2;
  localparam int WINDOW = 10 * 64;
  localparam int IVL    = (WINDOW - (4 + TRCD + TCAS + TRP)) / NROWS;
  localparam int ACC    = 2 + TRCD + TCAS + TRP;

  logic clk, rst_n;
  logic req_valid, req_ready, req_wr, rsp_valid;
  logic [2*AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rsp_rdata, dq_out, dq_in;
  logic [AW-1:0] dram_addr;
  logic ras_n, cas_n, we_n, dq_oe;

  int checks = 0;
  int errors = 0;

  dram_ctl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_KHZ(10), .RETENTION_MS(64),
    .T_RCD(TRCD), .T_CAS(TCAS), .T_RP(TRP)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dram_addr(dram_addr), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
    .dram_we_n(we_n), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe),
    .dram_dq_in(dq_in)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] init_val(input int a);
    return DW'(a) ^ 8'hA5;
  endfunction

  // Device model and interface monitor
  logic [DW-1:0] mem [NROWS][NROWS];
  logic [DW-1:0] shadow [NROWS*NROWS];
  logic [AW-1:0] m_row, m_col;
  assign dq_in = mem[m_row][m_col];

  bit mon_en = 0;
  int cyc = 0;
  logic p_ras = 1, p_cas = 1, p_we = 1;
  logic [AW-1:0] p_addr = '0;
  int ras_lo = 0, ras_hi = 0, cas_lo = 0;
  bit cas_seen = 0, ras_started = 0, ref_any = 0;
  int last_ref = 0, ref_count = 0;
  int exp_ref_row = 0;
  int row_last [NROWS];
  bit row_seen [NROWS];

  initial begin
    m_row = '0;
    m_col = '0;
    for (int r = 0; r < NROWS; r++) begin
      row_seen[r] = 0;
      row_last[r] = 0;
      for (int c = 0; c < NROWS; c++) begin
        mem[r][c] = init_val(r*NROWS + c);
        shadow[r*NROWS + c] = init_val(r*NROWS + c);
      end
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      cyc++;
      if (!ras_n) begin
        if (p_ras) begin
          chk(dram_addr == p_addr, "R2 row setup", int'(dram_addr), int'(p_addr));
          if (ras_started) chk(ras_hi >= TRP + 1, "R3 precharge", ras_hi, TRP + 1);
          ras_started = 1;
          m_row = dram_addr;
          cas_seen = 0;
          ras_lo = 1;
        end else ras_lo++;
      end
      if (!cas_n) begin
        if (p_cas) begin
          chk(!ras_n, "R3 cas under ras", int'(ras_n), 0);
          chk(ras_lo == TRCD + 2, "R3 ras-to-cas", ras_lo - 1, TRCD + 1);
          chk(dram_addr == p_addr, "R2 col setup", int'(dram_addr), int'(p_addr));
          chk(we_n == p_we, "R4 we setup", int'(we_n), int'(p_we));
          m_col = dram_addr;
          cas_seen = 1;
          cas_lo = 1;
          if (!we_n) begin
            chk(dq_oe, "R4 write drive", int'(dq_oe), 1);
            mem[m_row][dram_addr] = dq_out;
          end else begin
            chk(!dq_oe, "R4 read no drive", int'(dq_oe), 0);
          end
        end else begin
          cas_lo++;
          chk(we_n == p_we, "R4 we hold", int'(we_n), int'(p_we));
        end
      end else if (!p_cas) begin
        chk(cas_lo == TCAS, "R3 cas width", cas_lo, TCAS);
      end
      if (ras_n) begin
        if (!p_ras) begin
          ras_hi = 1;
          if (!cas_seen) begin
            ref_count++;
            chk(ras_lo == TRCD + TCAS, "R6 refresh width", ras_lo, TRCD + TCAS);
            chk(int'(m_row) == exp_ref_row, "R6 refresh row", int'(m_row), exp_ref_row);
            exp_ref_row = (exp_ref_row + 1) % NROWS;
            if (ref_any) begin
              chk(cyc - last_ref <= IVL + ACC + 2, "R8 refresh gap max", cyc - last_ref, IVL + ACC + 2);
              chk(cyc - last_ref >= IVL - ACC - 2, "R7 refresh gap min", cyc - last_ref, IVL - ACC - 2);
            end
            if (row_seen[m_row])
              chk(cyc - row_last[m_row] <= WINDOW, "R7 row window", cyc - row_last[m_row], WINDOW);
            row_seen[m_row] = 1;
            row_last[m_row] = cyc;
            last_ref = cyc;
            ref_any = 1;
          end
        end else ras_hi++;
      end
    end
    p_ras = ras_n;
    p_cas = cas_n;
    p_we = we_n;
    p_addr = dram_addr;
  end

  // Request driver
  task automatic issue(input bit wr, input logic [2*AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_wr    = wr;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 busy after accept", int'(req_ready), 0);
    if (wr) shadow[a] = d;
  endtask

  task automatic do_read(input logic [2*AW-1:0] a);
    bit got = 0;
    issue(1'b0, a, '0);
    for (int i = 0; i < 40 && !got; i++) begin
      if (rsp_valid) got = 1;
      else @(negedge clk);
    end
    chk(got, "R5 response seen", int'(got), 1);
    chk(rsp_rdata == shadow[a], "R5 read data", int'(rsp_rdata), int'(shadow[a]));
    @(negedge clk);
    chk(!rsp_valid, "R5 one-cycle valid", int'(rsp_valid), 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_wr = 1'b0;
    req_addr = '0;
    req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes idle", int'({ras_n, cas_n, we_n}), 7);
    chk(!dq_oe, "R1 no drive", int'(dq_oe), 0);
    chk(!rsp_valid, "R1 no response", int'(rsp_valid), 0);
    rst_n = 1'b1;
    mon_en = 1;
    repeat (3) @(negedge clk);
    chk(req_ready, "R1 ready after reset", int'(req_ready), 1);
    chk(ras_n && cas_n, "R1 strobes after reset", int'({ras_n, cas_n}), 3);
  endtask

  task automatic t_write_read;
    issue(1'b1, 8'h00, 8'h11);
    issue(1'b1, 8'hFF, 8'hEE);
    issue(1'b1, 8'hF0, 8'h3C);
    issue(1'b1, 8'h0F, 8'hC3);
    issue(1'b1, 8'h5A, 8'h77);
    chk(mem[15][0] == 8'h3C, "R2 row/col split", int'(mem[15][0]), 8'h3C);
    chk(mem[0][15] == 8'hC3, "R2 row/col split", int'(mem[0][15]), 8'hC3);
    do_read(8'h00);
    do_read(8'hFF);
    do_read(8'hF0);
    do_read(8'h0F);
    do_read(8'h5A);
  endtask

  task automatic t_read_untouched;
    do_read(8'h21);
    do_read(8'hA7);
  endtask

  task automatic t_saturate;
    int c0 = cyc;
    int r0 = ref_count;
    for (int i = 0; i < 40; i++)
      issue(i[0], 8'(i * 37), 8'(i * 5 + 1));
    chk(ref_count - r0 >= (cyc - c0) / IVL - 1, "R8 refresh under load",
        ref_count - r0, (cyc - c0) / IVL - 1);
    do_read(8'(37));
  endtask

  task automatic t_idle_refresh;
    int r0 = ref_count;
    bit all = 1;
    repeat (2 * WINDOW) @(negedge clk);
    chk(ref_count - r0 >= (2 * WINDOW) / IVL - 1, "R7 idle refresh count",
        ref_count - r0, (2 * WINDOW) / IVL - 1);
    for (int r = 0; r < NROWS; r++) if (!row_seen[r]) all = 0;
    chk(all, "R6 every row refreshed", int'(all), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(0, "WATCHDOG", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_write_read();
    t_read_untouched();
    t_saturate();
    t_idle_refresh();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule